// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It reads one 64-bit table entry per level from memory, through a simple read port. The tables are walked from the top level down. At each level, nine bits of the virtual address select one of 512 entries, and each non-leaf entry names the frame of the next table. A walk ends in one of two ways:
- at the bottom level, with a 4 KiB page;
- at the second level, with a 2 MiB page, when that entry has its large-page flag set.

The walker gathers permission bits from every entry it reads. When the walk ends, it checks the request's access flags against them: write, user mode and instruction fetch.

A translation is requested with a valid/ready handshake, and the walker accepts one only when it is idle. The result comes back as a single-cycle completion pulse. The pulse carries either the physical address or a fault flag together with a bit-coded error code. The code tells a missing mapping apart from a refused access.

Top module: `ptw_walker`

## Requirements
- R1: Table-entry addresses are {table frame, index, 3'b000}. The walk starts at the root frame. The indices are used in the order va[47:39], va[38:30], va[29:21], va[20:12], and each later frame is taken from bits 51:12 of the entry just read.
- R2: When every entry is usable, a 4 KiB walk makes exactly four reads. It completes with physical address {L1 entry[51:12], va[11:0]} and with done_fault low.
- R3: If a level-2 entry has bit 0 and bit 7 set, the walk stops after three reads. It completes with physical address {entry[51:21], va[20:0]}.
- R4: An entry with bit 0 clear ends the walk at once, with no further reads. It reports a fault with code bit 0 = 0, code bit 1 = the write flag, code bit 2 = the user flag, and code bits 3 and 4 = 0.
- R5: If req_vaddr[63:48] are not all equal to req_vaddr[47], the walker reports the not-present fault code of R4 and makes no memory read.
- R6: A write is refused unless bit 1 is set in every entry visited. A refused access has code bit 0 = 1, bit 1 = write flag, bit 2 = user flag, and bit 4 = fetch flag AND (some entry visited has bit 63 set).
- R7: A user-mode access is refused unless bit 2 is set in every entry visited. A supervisor access ignores bit 2, including a supervisor write, which still needs bit 1.
- R8: An instruction fetch is refused when any entry visited has bit 63 set, and the refusal has code bit 4 = 1. A data read of the same mapping is allowed.
- R9: At most one memory read is outstanding. mem_req_valid and mem_req_addr stay steady while mem_req_ready is low. req_ready is high only while idle.
- R10: done_valid is a single-cycle pulse per accepted request. While it is high, no memory request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 64 | Virtual address, sign-extended from bit 47 |
| req_root | input | 40 | Frame number (address bits 51:12) of the top-level table |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry read from memory |
| done_valid | output | 1 | Completion pulse |
| done_fault | output | 1 | Translation faulted |
| done_paddr | output | 52 | Physical address (valid when not faulted) |
| done_code | output | 5 | Fault code (bits 0,1,2,4 used; bit 3 zero) |

## Verification
A wrong level counter or frame register shows at the memory port. It appears on the very next read as an address outside the expected chain, or as the wrong number of reads before the completion pulse. Wrong accumulated permissions stay hidden until the walk ends, and then show as a wrong fault flag or code bit in the completion cycle. The tests therefore record every read address and count the reads. They also build tables that refuse access at an inner level, so a design that checks only the leaf entry returns a wrong verdict.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    parameter int unsigned VIN_W   = 64;
    parameter int unsigned VA_W    = 48;
    parameter int unsigned PA_W    = 52;
    parameter int unsigned OFF_W   = 12;
    parameter int unsigned IDX_W   = 9;
    parameter int unsigned LEVELS  = 4;
    parameter int unsigned ENT_W   = 64;
    parameter int unsigned CODE_W  = 5;

    localparam int unsigned FRAME_W = PA_W - OFF_W;
    localparam int unsigned LVL_W   = $clog2(LEVELS);
    localparam int unsigned ENT_SH  = $clog2(ENT_W / 8);
    localparam int unsigned BIG_W   = OFF_W + IDX_W;

    // entry bit positions
    localparam int unsigned B_VALID = 0;
    localparam int unsigned B_WRITE = 1;
    localparam int unsigned B_USER  = 2;
    localparam int unsigned B_LARGE = 7;
    localparam int unsigned B_NX    = 63;

    // fault code bit positions
    localparam int unsigned C_PROT  = 0;
    localparam int unsigned C_WR    = 1;
    localparam int unsigned C_USR   = 2;
    localparam int unsigned C_IF    = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} walk_state_e;

    typedef struct packed {
        walk_state_e          st;
        logic [LVL_W-1:0]     lvl;
        logic [FRAME_W-1:0]   base;
        logic [VA_W-1:0]      va;
        logic                 wr;
        logic                 usr;
        logic                 fetch;
        logic                 w_ok;
        logic                 u_ok;
        logic                 nx;
        logic                 fault;
        logic [CODE_W-1:0]    code;
        logic [PA_W-1:0]      pa;
    } walk_regs_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [FRAME_W-1:0]    base,
    input  logic [VA_W-1:OFF_W]   va_hi,
    input  logic [LVL_W-1:0]      lvl,
    output logic [PA_W-1:0]       addr
);
    logic [IDX_W-1:0] idx_tab [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_tab[g] = va_hi[OFF_W + g*IDX_W +: IDX_W];
    end

    assign addr = {base, idx_tab[lvl], {ENT_SH{1'b0}}};
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic              w_ok_in,
    input  logic              u_ok_in,
    input  logic              nx_in,
    input  logic              ent_w,
    input  logic              ent_u,
    input  logic              ent_nx,
    input  logic              wr,
    input  logic              usr,
    input  logic              fetch,
    output logic              w_all,
    output logic              u_all,
    output logic              nx_any,
    output logic              deny,
    output logic [CODE_W-1:0] prot_code
);
    always_comb begin
        w_all  = w_ok_in & ent_w;
        u_all  = u_ok_in & ent_u;
        nx_any = nx_in | ent_nx;
        deny   = (wr & ~w_all) | (usr & ~u_all) | (fetch & nx_any);
        prot_code         = '0;
        prot_code[C_PROT] = 1'b1;
        prot_code[C_WR]   = wr;
        prot_code[C_USR]  = usr;
        prot_code[C_IF]   = fetch & nx_any;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VIN_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0]  req_root,
    input  logic                req_write,
    input  logic                req_user,
    input  logic                req_fetch,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [PA_W-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [ENT_W-1:0]    mem_rsp_data,
    output logic                done_valid,
    output logic                done_fault,
    output logic [PA_W-1:0]     done_paddr,
    output logic [CODE_W-1:0]   done_code
);
    walk_regs_t r_q, r_d;

    logic              w_all, u_all, nx_any, deny;
    logic [CODE_W-1:0] prot_code;
    logic              canon;
    logic [VIN_W-VA_W:0] sext;
    logic              unused_bits;

    assign sext  = req_vaddr[VIN_W-1:VA_W-1];
    assign canon = (&sext) | ~(|sext);
    assign unused_bits = ^{mem_rsp_data[ENT_W-2:PA_W], mem_rsp_data[OFF_W-1:B_LARGE+1],
                           mem_rsp_data[B_LARGE-1:B_USER+1], r_q.va[OFF_W-1:0]};

    ptw_addr_gen u_addr (
        .base  (r_q.base),
        .va_hi (r_q.va[VA_W-1:OFF_W]),
        .lvl   (r_q.lvl),
        .addr  (mem_req_addr)
    );

    ptw_perm_check u_perm (
        .w_ok_in   (r_q.w_ok),
        .u_ok_in   (r_q.u_ok),
        .nx_in     (r_q.nx),
        .ent_w     (mem_rsp_data[B_WRITE]),
        .ent_u     (mem_rsp_data[B_USER]),
        .ent_nx    (mem_rsp_data[B_NX]),
        .wr        (r_q.wr),
        .usr       (r_q.usr),
        .fetch     (r_q.fetch),
        .w_all     (w_all),
        .u_all     (u_all),
        .nx_any    (nx_any),
        .deny      (deny),
        .prot_code (prot_code)
    );

    function automatic logic [CODE_W-1:0] absent_code(input logic wr, input logic usr);
        logic [CODE_W-1:0] c;
        c        = '0;
        c[C_WR]  = wr;
        c[C_USR] = usr;
        return c;
    endfunction

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.va    = req_vaddr[VA_W-1:0];
                    r_d.base  = req_root;
                    r_d.wr    = req_write;
                    r_d.usr   = req_user;
                    r_d.fetch = req_fetch;
                    r_d.lvl   = LVL_W'(LEVELS - 1);
                    r_d.w_ok  = 1'b1;
                    r_d.u_ok  = 1'b1;
                    r_d.nx    = 1'b0;
                    r_d.fault = 1'b0;
                    r_d.code  = '0;
                    r_d.pa    = '0;
                    if (!canon) begin
                        r_d.fault = 1'b1;
                        r_d.code  = absent_code(req_write, req_user);
                        r_d.st    = ST_DONE;
                    end else begin
                        r_d.st    = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!mem_rsp_data[B_VALID]) begin
                        r_d.fault = 1'b1;
                        r_d.code  = absent_code(r_q.wr, r_q.usr);
                        r_d.st    = ST_DONE;
                    end else begin
                        r_d.w_ok = w_all;
                        r_d.u_ok = u_all;
                        r_d.nx   = nx_any;
                        if (r_q.lvl == '0 ||
                            (r_q.lvl == LVL_W'(1) && mem_rsp_data[B_LARGE])) begin
                            r_d.st = ST_DONE;
                            if (deny) begin
                                r_d.fault = 1'b1;
                                r_d.code  = prot_code;
                            end else if (r_q.lvl == '0) begin
                                r_d.pa = {mem_rsp_data[PA_W-1:OFF_W], r_q.va[OFF_W-1:0]};
                            end else begin
                                r_d.pa = {mem_rsp_data[PA_W-1:BIG_W], r_q.va[BIG_W-1:0]};
                            end
                        end else begin
                            r_d.base = mem_rsp_data[PA_W-1:OFF_W];
                            r_d.lvl  = r_q.lvl - LVL_W'(1);
                            r_d.st   = ST_ISSUE;
                        end
                    end
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_ISSUE);
    assign done_valid    = (r_q.st == ST_DONE);
    assign done_fault    = r_q.fault;
    assign done_paddr    = r_q.pa;
    assign done_code     = r_q.code;

    // R9: a granted read is not followed at once by another request
    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R9: a stalled request keeps its address
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9: after accepting a request the walker is busy
    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: completion is one cycle wide
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R10: no memory traffic during completion
    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !mem_req_valid);

    // R4: a not-present entry stops the walk
    assert_absent_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && mem_rsp_valid && !mem_rsp_data[B_VALID]) |=> (done_valid && done_fault && !done_code[C_PROT]));

    // R5: a non-canonical address completes without a read
    assert_noncanon_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !canon) |=> (done_valid && done_fault));
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [39:0] req_root = '0;
    logic        req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done_valid, done_fault;
    logic [51:0] done_paddr;
    logic [4:0]  done_code;

    int checks = 0;
    int errors = 0;
    int reads = 0;
    bit stall_mode = 1'b0;
    logic [63:0] mem [logic [51:0]];
    logic [51:0] addr_log [8];

    localparam logic [39:0] ROOT = 40'h00100;
    localparam logic [39:0] F3   = 40'h00200;
    localparam logic [39:0] F2   = 40'h00300;
    localparam logic [39:0] F1   = 40'h00400;
    localparam logic [39:0] PG   = 40'hABCDE;

    always #2.5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_root(req_root), .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_fault(done_fault), .done_paddr(done_paddr), .done_code(done_code)
    );

    // memory model: response one cycle after a granted read
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
            if (reads < 8) addr_log[reads] <= mem_req_addr;
            reads <= reads + 1;
        end
        mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [39:0] frame, input logic [8:0] idx, input logic [63:0] data);
        mem[{frame, idx, 3'b000}] = data;
    endtask

    function automatic logic [63:0] ent(input logic [39:0] frame, input logic [11:0] flags, input bit nx);
        return {nx, 11'd0, frame, flags};
    endfunction

    // builds the four-level chain for va; per-level flags given top first
    task automatic build(input logic [63:0] va, input logic [11:0] f4, input logic [11:0] f3,
                         input logic [11:0] f2, input logic [11:0] f1, input bit nx4);
        mem.delete();
        put(ROOT, va[47:39], ent(F3, f4, nx4));
        put(F3,   va[38:30], ent(F2, f3, 1'b0));
        put(F2,   va[29:21], ent(F1, f2, 1'b0));
        put(F1,   va[20:12], ent(PG, f1, 1'b0));
    endtask

    task automatic run(input logic [63:0] va, input bit wr, input bit usr, input bit fe);
        @(negedge clk);
        reads = 0;
        req_valid = 1'b1; req_vaddr = va; req_root = ROOT;
        req_write = wr; req_user = usr; req_fetch = fe;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 200 && !done_valid; i++) @(negedge clk);
        check(done_valid === 1'b1, "R10 completion seen", {63'd0, done_valid}, 64'd1);
    endtask

    task automatic t_reset;
        check(req_ready === 1'b1, "R9 idle ready after reset", {63'd0, req_ready}, 64'd1);
        check(done_valid === 1'b0 && mem_req_valid === 1'b0, "R10 quiet after reset",
              {62'd0, done_valid, mem_req_valid}, 64'd0);
    endtask

    task automatic t_walk4k(input string tag);
        logic [63:0] va = 64'h0000_7F12_3456_7ABC;
        build(va, 12'h007, 12'h007, 12'h007, 12'h007, 1'b0);
        run(va, 1'b1, 1'b1, 1'b0);
        check(done_fault === 1'b0, {tag, " R2 no fault"}, {63'd0, done_fault}, 64'd0);
        check(done_paddr === {PG, va[11:0]}, {tag, " R2 paddr"}, {12'd0, done_paddr}, {12'd0, PG, va[11:0]});
        @(negedge clk);
        check(done_valid === 1'b0, {tag, " R10 single pulse"}, {63'd0, done_valid}, 64'd0);
        check(reads == 4, {tag, " R2 four reads"}, 64'(reads), 64'd4);
        check(addr_log[0] === {ROOT, va[47:39], 3'b0}, {tag, " R1 L4 addr"}, {12'd0, addr_log[0]}, {12'd0, ROOT, va[47:39], 3'b0});
        check(addr_log[1] === {F3, va[38:30], 3'b0}, {tag, " R1 L3 addr"}, {12'd0, addr_log[1]}, {12'd0, F3, va[38:30], 3'b0});
        check(addr_log[2] === {F2, va[29:21], 3'b0}, {tag, " R1 L2 addr"}, {12'd0, addr_log[2]}, {12'd0, F2, va[29:21], 3'b0});
        check(addr_log[3] === {F1, va[20:12], 3'b0}, {tag, " R1 L1 addr"}, {12'd0, addr_log[3]}, {12'd0, F1, va[20:12], 3'b0});
    endtask

    task automatic t_walk2m;
        logic [63:0] va = 64'hFFFF_8000_0020_1357;
        logic [63:0] big = {12'd0, 31'h0001_2345, 21'd0} | 64'h87;
        build(va, 12'h007, 12'h007, 12'h007, 12'h007, 1'b0);
        put(F2, va[29:21], big);
        run(va, 1'b0, 1'b0, 1'b0);
        check(done_fault === 1'b0, "R3 no fault", {63'd0, done_fault}, 64'd0);
        check(done_paddr === {31'h0001_2345, va[20:0]}, "R3 paddr", {12'd0, done_paddr}, {12'd0, 31'h0001_2345, va[20:0]});
        @(negedge clk);
        check(reads == 3, "R3 three reads", 64'(reads), 64'd3);
    endtask

    task automatic t_absent;
        logic [63:0] va = 64'h0000_1111_2222_3333;
        build(va, 12'h007, 12'h006, 12'h007, 12'h007, 1'b0);
        run(va, 1'b1, 1'b1, 1'b0);
        check(done_fault === 1'b1 && done_code === 5'b00110, "R4 absent code",
              {58'd0, done_fault, done_code}, {58'd0, 1'b1, 5'b00110});
        @(negedge clk);
        check(reads == 2, "R4 walk stops", 64'(reads), 64'd2);
    endtask

    task automatic t_noncanon;
        logic [63:0] va = 64'h0001_0000_0000_0000;
        mem.delete();
        run(va, 1'b1, 1'b0, 1'b0);
        check(done_fault === 1'b1 && done_code === 5'b00010, "R5 noncanonical code",
              {58'd0, done_fault, done_code}, {58'd0, 1'b1, 5'b00010});
        @(negedge clk);
        check(reads == 0, "R5 no reads", 64'(reads), 64'd0);
    endtask

    task automatic t_write_deny;
        logic [63:0] va = 64'h0000_0ABC_DEF0_1234;
        build(va, 12'h003, 12'h003, 12'h001, 12'h003, 1'b0);
        run(va, 1'b1, 1'b0, 1'b0);
        check(done_fault === 1'b1 && done_code === 5'b00011, "R6 write refused by inner level",
              {58'd0, done_fault, done_code}, {58'd0, 1'b1, 5'b00011});
        run(va, 1'b0, 1'b0, 1'b0);
        check(done_fault === 1'b0 && done_paddr === {PG, va[11:0]}, "R6 read allowed",
              {11'd0, done_fault, done_paddr}, {12'd0, PG, va[11:0]});
    endtask

    task automatic t_user;
        logic [63:0] va = 64'h0000_2222_4444_6666;
        build(va, 12'h007, 12'h003, 12'h007, 12'h007, 1'b0);
        run(va, 1'b1, 1'b0, 1'b0);
        check(done_fault === 1'b0, "R7 supervisor ignores user bit", {63'd0, done_fault}, 64'd0);
        run(va, 1'b0, 1'b1, 1'b0);
        check(done_fault === 1'b1 && done_code === 5'b00101, "R7 user refused",
              {58'd0, done_fault, done_code}, {58'd0, 1'b1, 5'b00101});
    endtask

    task automatic t_nx;
        logic [63:0] va = 64'h0000_3333_5555_7777;
        build(va, 12'h007, 12'h007, 12'h007, 12'h007, 1'b1);
        run(va, 1'b0, 1'b0, 1'b1);
        check(done_fault === 1'b1 && done_code === 5'b10001, "R8 fetch refused",
              {58'd0, done_fault, done_code}, {58'd0, 1'b1, 5'b10001});
        run(va, 1'b0, 1'b0, 1'b0);
        check(done_fault === 1'b0 && done_paddr === {PG, va[11:0]}, "R8 data read allowed",
              {11'd0, done_fault, done_paddr}, {12'd0, PG, va[11:0]});
    endtask

    task automatic t_stall;
        stall_mode = 1'b1;
        t_walk4k("R9 stalled");
        stall_mode = 1'b0;
        check(req_ready === 1'b1, "R9 ready again when idle", {63'd0, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_walk4k("R2 plain");
        t_walk2m();
        t_absent();
        t_noncanon();
        t_write_deny();
        t_user();
        t_nx();
        t_stall();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule